// File: doc/BRIEF.md
# Programmable-Length Serial Word Shifter

This block moves 24-bit parallel words onto and off a one-bit serial line, most significant bit first, with the word length chosen by a 3-bit code. The transmit half latches a holding word on a load strobe. It then emits the selected number of bits, one for each cycle in which the shared bit-clock enable is high, and pulses a done strobe when the last bit has gone. The receive half is armed by a start strobe. It samples the serial input on the same enable and presents the assembled, left-aligned 24-bit word together with a one-cycle valid strobe.

An alignment select moves the reference bit of the short word lengths from bit 23 to bit 15, for systems that carry 16-bit data. Two 32-bit codes fill the extra eight bit times by repeating one edge bit of the 24-bit register. A length code that is not allowed raises a configuration error flag, and a load or start seen under such a code is refused. The transmit and receive halves share the decoder and the bit-position mapping logic, but they run independently, so a bench can tie them together in loopback.

Top module: `serial_word_shifter`

## Requirements
- R1: The length code selects the number of bits in one word: 000 gives 8, 001 gives 12, 010 gives 16, 011 gives 24. Codes 100 and 101 each give 32.
- R2: With align16_i low, the transmitter sends bit 23 of the latched word first and then moves down one bit position for each bit sent.
- R3: With align16_i high, a short word starts at bit 15 of the latched word and moves downward from there.
- R4: Code 100 sends bits 23..0 and then eight further copies of bit 0.
- R5: Code 101 sends eight copies of bit 23 and then bits 23..0.
- R6: The receiver writes incoming bits from bit 23 downward, or from bit 15 downward when align16_i is high. Every position the word does not reach reads as zero, and that includes bits 23..16 in the bit-15 alignment.
- R7: In both 32-bit codes the receiver drops the eight padding bit times. For code 100 these are the last eight bits, and for code 101 the first eight. The 24 data bits land in bits 23..0.
- R8: cfg_err_o is high for codes 110 and 111, and for align16_i high together with code 011, 100 or 101. While cfg_err_o is high, a load or start strobe starts no transfer.
- R9: Exactly one bit is shifted or sampled on each rising edge where bit_en_i is high. While bit_en_i is low, tx_bit_o and the bit counters hold their values.
- R10: tx_done_o and rx_valid_o are each one-cycle pulses in the cycle after the last bit is taken. A load in the tx_done_o cycle is accepted. A load while tx_busy_o is high is ignored.
- R11: After reset, tx_busy_o, tx_bit_o, tx_done_o, rx_valid_o and rx_data_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-clock enable shared by both halves |
| wl_code_i | input | 3 | Word-length code |
| align16_i | input | 1 | Use bit 15 instead of bit 23 as the alignment point |
| cfg_err_o | output | 1 | Current configuration is not allowed |
| tx_load_i | input | 1 | Latch tx_data_i and start a transmit word |
| tx_data_i | input | 24 | Parallel word to transmit |
| tx_bit_o | output | 1 | Serial transmit bit |
| tx_busy_o | output | 1 | Transmit word in progress |
| tx_done_o | output | 1 | One-cycle pulse after the last transmit bit |
| rx_start_i | input | 1 | Arm the receiver for one word |
| rx_bit_i | input | 1 | Serial receive bit |
| rx_data_o | output | 24 | Last received word, left-aligned |
| rx_valid_o | output | 1 | One-cycle pulse when rx_data_o updates |

## Verification
Two events can fall in the same cycle: the transmitter finishing a word, and a new load arriving. The bench therefore drives tx_load_i in the very cycle tx_done_o is high. It judges the result by tx_busy_o rising at once and by the first bit of the second word appearing with no idle bit time between the words. A second pairing is a stray load that lands in the middle of a word. The check is that the serial stream stays bit-exact to the first word. Transmit and receive run in loopback under the same enable, and the enable is sometimes held low, so stalls happen partway through a word in both halves together.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic [2:0] {
    WL_8       = 3'd0,
    WL_12      = 3'd1,
    WL_16      = 3'd2,
    WL_24      = 3'd3,
    WL_32_TAIL = 3'd4,
    WL_32_HEAD = 3'd5,
    WL_RSV6    = 3'd6,
    WL_RSV7    = 3'd7
  } wl_code_e;
endpackage

// File: rtl/sws_len_decode.sv
module sws_len_decode
  import sws_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int PAD_W  = 8,
  localparam int CNT_W = $clog2(DATA_W + PAD_W + 1)
) (
  input  wl_code_e           code_i,
  input  logic               align16_i,
  output logic [CNT_W-1:0]   nbits_o,
  output logic               err_o
);
  always_comb begin
    err_o = 1'b0;
    unique case (code_i)
      WL_8:       nbits_o = CNT_W'(8);
      WL_12:      nbits_o = CNT_W'(12);
      WL_16:      nbits_o = CNT_W'(16);
      WL_24:      nbits_o = CNT_W'(DATA_W);
      WL_32_TAIL,
      WL_32_HEAD: nbits_o = CNT_W'(DATA_W + PAD_W);
      default: begin
        nbits_o = CNT_W'(DATA_W);
        err_o   = 1'b1;
      end
    endcase
    // narrow alignment only legal for short words
    if (align16_i && (code_i >= WL_24)) err_o = 1'b1;
  end
endmodule

// File: rtl/sws_lane_map.sv
module sws_lane_map
  import sws_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int PAD_W   = 8,
  parameter int ALT_TOP = 15,
  localparam int CNT_W  = $clog2(DATA_W + PAD_W + 1),
  localparam int POS_W  = $clog2(DATA_W)
) (
  input  wl_code_e           code_i,
  input  logic               align16_i,
  input  logic [CNT_W-1:0]   idx_i,
  output logic [POS_W-1:0]   pos_o,
  output logic               hit_o
);
  logic [CNT_W-1:0] top;
  logic [CNT_W-1:0] pos_w;

  always_comb begin
    top   = align16_i ? CNT_W'(ALT_TOP) : CNT_W'(DATA_W - 1);
    hit_o = 1'b1;
    unique case (code_i)
      WL_32_TAIL: begin
        if (idx_i < CNT_W'(DATA_W)) begin
          pos_w = CNT_W'(DATA_W - 1) - idx_i;
        end else begin
          pos_w = '0;          // repeat last bit
          hit_o = 1'b0;
        end
      end
      WL_32_HEAD: begin
        if (idx_i < CNT_W'(PAD_W)) begin
          pos_w = CNT_W'(DATA_W - 1);  // repeat first bit
          hit_o = 1'b0;
        end else begin
          pos_w = CNT_W'(DATA_W - 1 + PAD_W) - idx_i;
        end
      end
      default: pos_w = top - idx_i;
    endcase
  end

  assign pos_o = pos_w[POS_W-1:0];
endmodule

// File: rtl/sws_tx.sv
module sws_tx
  import sws_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int PAD_W   = 8,
  parameter int ALT_TOP = 15,
  localparam int CNT_W  = $clog2(DATA_W + PAD_W + 1),
  localparam int POS_W  = $clog2(DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               load_i,
  input  logic [DATA_W-1:0]  data_i,
  input  wl_code_e           code_i,
  input  logic               align16_i,
  input  logic [CNT_W-1:0]   nbits_i,
  input  logic               err_i,
  output logic               bit_o,
  output logic               busy_o,
  output logic               done_o
);
  logic [DATA_W-1:0] data_q;
  wl_code_e          code_q;
  logic              align_q;
  logic [CNT_W-1:0]  nbits_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              done_q;
  logic [POS_W-1:0]  pos;
  logic              hit_unused;

  sws_lane_map #(.DATA_W(DATA_W), .PAD_W(PAD_W), .ALT_TOP(ALT_TOP)) i_map (
    .code_i    (code_q),
    .align16_i (align_q),
    .idx_i     (cnt_q),
    .pos_o     (pos),
    .hit_o     (hit_unused)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      code_q  <= WL_8;
      align_q <= 1'b0;
      nbits_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (load_i && !err_i) begin
          data_q  <= data_i;
          code_q  <= code_i;
          align_q <= align16_i;
          nbits_q <= nbits_i;
          cnt_q   <= '0;
          busy_q  <= 1'b1;
        end
      end else if (bit_en_i) begin
        if (cnt_q == nbits_q - CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign bit_o  = busy_q & data_q[pos];
  assign busy_o = busy_q;
  assign done_o = done_q;

  // R10
  tx_done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  // R8
  tx_start_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(load_i && !err_i));
  // R1
  tx_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < nbits_q));
  // R9
  tx_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !bit_en_i) |=> (busy_q && $stable(cnt_q) && $stable(bit_o)));
endmodule

// File: rtl/sws_rx.sv
module sws_rx
  import sws_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int PAD_W   = 8,
  parameter int ALT_TOP = 15,
  localparam int CNT_W  = $clog2(DATA_W + PAD_W + 1),
  localparam int POS_W  = $clog2(DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               start_i,
  input  logic               bit_i,
  input  wl_code_e           code_i,
  input  logic               align16_i,
  input  logic [CNT_W-1:0]   nbits_i,
  input  logic               err_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               valid_o
);
  logic [DATA_W-1:0] acc_q, acc_d, data_q;
  wl_code_e          code_q;
  logic              align_q;
  logic [CNT_W-1:0]  nbits_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              act_q;
  logic              valid_q;
  logic [POS_W-1:0]  pos;
  logic              hit;

  sws_lane_map #(.DATA_W(DATA_W), .PAD_W(PAD_W), .ALT_TOP(ALT_TOP)) i_map (
    .code_i    (code_q),
    .align16_i (align_q),
    .idx_i     (cnt_q),
    .pos_o     (pos),
    .hit_o     (hit)
  );

  always_comb begin
    acc_d = acc_q;
    if (hit) acc_d[pos] = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      data_q  <= '0;
      code_q  <= WL_8;
      align_q <= 1'b0;
      nbits_q <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!act_q) begin
        if (start_i && !err_i) begin
          acc_q   <= '0;
          code_q  <= code_i;
          align_q <= align16_i;
          nbits_q <= nbits_i;
          cnt_q   <= '0;
          act_q   <= 1'b1;
        end
      end else if (bit_en_i) begin
        acc_q <= acc_d;
        if (cnt_q == nbits_q - CNT_W'(1)) begin
          act_q   <= 1'b0;
          valid_q <= 1'b1;
          data_q  <= acc_d;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  // R10
  rx_valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> !act_q);
  // R6
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(data_q));
  // R8
  rx_start_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(start_i && !err_i));
  // R9
  rx_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !bit_en_i) |=> (act_q && $stable(cnt_q) && $stable(acc_q)));
endmodule

// File: rtl/serial_word_shifter.sv
module serial_word_shifter
  import sws_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int PAD_W   = 8,
  parameter int ALT_TOP = 15,
  localparam int CNT_W  = $clog2(DATA_W + PAD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [2:0]        wl_code_i,
  input  logic              align16_i,
  output logic              cfg_err_o,
  input  logic              tx_load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_bit_o,
  output logic              tx_busy_o,
  output logic              tx_done_o,
  input  logic              rx_start_i,
  input  logic              rx_bit_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  wl_code_e         code;
  logic [CNT_W-1:0] nbits;
  logic             err;

  assign code = wl_code_e'(wl_code_i);

  sws_len_decode #(.DATA_W(DATA_W), .PAD_W(PAD_W)) i_dec (
    .code_i    (code),
    .align16_i (align16_i),
    .nbits_o   (nbits),
    .err_o     (err)
  );

  sws_tx #(.DATA_W(DATA_W), .PAD_W(PAD_W), .ALT_TOP(ALT_TOP)) i_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .load_i    (tx_load_i),
    .data_i    (tx_data_i),
    .code_i    (code),
    .align16_i (align16_i),
    .nbits_i   (nbits),
    .err_i     (err),
    .bit_o     (tx_bit_o),
    .busy_o    (tx_busy_o),
    .done_o    (tx_done_o)
  );

  sws_rx #(.DATA_W(DATA_W), .PAD_W(PAD_W), .ALT_TOP(ALT_TOP)) i_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .start_i   (rx_start_i),
    .bit_i     (rx_bit_i),
    .code_i    (code),
    .align16_i (align16_i),
    .nbits_i   (nbits),
    .err_i     (err),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o)
  );

  assign cfg_err_o = err;

  // R8
  cfg_err_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && tx_load_i && !tx_busy_o) |=> !tx_busy_o);
endmodule

// File: tb/test_serial_word_shifter.sv
module test_serial_word_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic [2:0]  wl = 3'd0;
  logic        align = 1'b0;
  logic        cfg_err;
  logic        tx_load = 1'b0;
  logic [23:0] tx_data = '0;
  logic        tx_bit, tx_busy, tx_done;
  logic        rx_start = 1'b0;
  logic [23:0] rx_data;
  logic        rx_valid;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  serial_word_shifter i_serial_word_shifter (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bit_en_i   (bit_en),
    .wl_code_i  (wl),
    .align16_i  (align),
    .cfg_err_o  (cfg_err),
    .tx_load_i  (tx_load),
    .tx_data_i  (tx_data),
    .tx_bit_o   (tx_bit),
    .tx_busy_o  (tx_busy),
    .tx_done_o  (tx_done),
    .rx_start_i (rx_start),
    .rx_bit_i   (tx_bit),
    .rx_data_o  (rx_data),
    .rx_valid_o (rx_valid)
  );

  // {code, align, data}
  localparam logic [27:0] VEC [11] = '{
    {3'd0, 1'b0, 24'hA53C96}, {3'd1, 1'b0, 24'hC35AF1},
    {3'd2, 1'b0, 24'h123456}, {3'd3, 1'b0, 24'h9ABCDE},
    {3'd0, 1'b1, 24'hFF0081}, {3'd1, 1'b1, 24'h7EEDC3},
    {3'd2, 1'b1, 24'hABCDEF}, {3'd4, 1'b0, 24'h6B2DE1},
    {3'd5, 1'b0, 24'h80007F}, {3'd4, 1'b0, 24'hF0000E},
    {3'd5, 1'b0, 24'h4FFFFF}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nb_of(logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic exp_bit(logic [2:0] c, logic a, logic [23:0] d, int k);
    if (c == 3'd4) return (k < 24) ? d[23-k] : d[0];
    if (c == 3'd5) return (k < 8) ? d[23] : d[31-k];
    return a ? d[15-k] : d[23-k];
  endfunction

  function automatic logic [23:0] exp_rx(logic [2:0] c, logic a, logic [23:0] d);
    int n;
    logic [23:0] m;
    if (c >= 3'd3) return d;
    n = nb_of(c);
    m = 24'((32'h1 << n) - 1);
    m = a ? (m << (16 - n)) : (m << (24 - n));
    return d & m;
  endfunction

  function automatic string tag_tx(logic [2:0] c, logic a);
    if (c == 3'd4) return "R4";
    if (c == 3'd5) return "R5";
    return a ? "R3" : "R2";
  endfunction

  // starts and ends at a negedge; ends in the cycle tx_done is expected high
  task automatic run_vec(logic [2:0] c, logic a, logic [23:0] d, bit gap, bit inject);
    int n = nb_of(c);
    wl = c; align = a; tx_data = d; tx_load = 1'b1; rx_start = 1'b1; bit_en = 1'b0;
    @(negedge clk);
    tx_load = 1'b0; rx_start = 1'b0;
    chk("R1", 32'(tx_busy), 32'd1);
    for (int k = 0; k < n; k++) begin
      if (gap && (k % 5 == 2)) begin
        bit_en = 1'b0;
        @(negedge clk);
        chk("R9", 32'(tx_bit), 32'(exp_bit(c, a, d, k)));
      end
      chk(tag_tx(c, a), 32'(tx_bit), 32'(exp_bit(c, a, d, k)));
      chk("R1", 32'(tx_done), 32'd0);
      bit_en = 1'b1;
      if (inject && k == 2) begin
        tx_load = 1'b1; tx_data = ~d;   // R10: ignored while busy
      end
      @(negedge clk);
      tx_load = 1'b0; tx_data = d;
    end
    bit_en = 1'b0;
    chk("R1,R10", 32'(tx_done), 32'd1);
    chk("R10", 32'(rx_valid), 32'd1);
    chk("R10", 32'(tx_busy), 32'd0);
    chk((c >= 3'd4) ? "R7" : "R6", 32'(rx_data), 32'(exp_rx(c, a, d)));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R11
    chk("R11", 32'(tx_busy), 32'd0);
    chk("R11", 32'(tx_bit), 32'd0);
    chk("R11", 32'(tx_done), 32'd0);
    chk("R11", 32'(rx_valid), 32'd0);
    chk("R11", 32'(rx_data), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      run_vec(VEC[i][27:25], VEC[i][24], VEC[i][23:0], (i % 2) == 1, 1'b0);
      @(negedge clk);
      chk("R10", 32'(tx_done), 32'd0);
      chk("R10", 32'(rx_valid), 32'd0);
    end

    // R8: reserved codes and illegal alignment combos
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 2; a++) begin
        wl = 3'(c); align = a[0];
        @(negedge clk);
        chk("R8", 32'(cfg_err), 32'((c >= 6) || (a == 1 && c >= 3)));
      end
    end
    wl = 3'd6; align = 1'b0; tx_data = 24'hFFFFFF; tx_load = 1'b1; rx_start = 1'b1;
    bit_en = 1'b1;
    @(negedge clk);
    tx_load = 1'b0; rx_start = 1'b0;
    chk("R8", 32'(tx_busy), 32'd0);
    repeat (40) begin
      @(negedge clk);
      if (tx_done || rx_valid || tx_busy) chk("R8", 32'(tx_done | rx_valid | tx_busy), 32'd0);
    end
    chk("R8", 32'(rx_data), 32'(exp_rx(3'd4, 1'b0, 24'h4FFFFF)));
    wl = 3'd3; align = 1'b1; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0; bit_en = 1'b0;
    chk("R8", 32'(tx_busy), 32'd0);

    // R10: stray load mid-word, then a new load in the done cycle
    run_vec(3'd1, 1'b0, 24'h3C_A5_00, 1'b0, 1'b1);
    wl = 3'd0; align = 1'b0; tx_data = 24'h81_0000; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    chk("R10", 32'(tx_busy), 32'd1);
    chk("R10", 32'(tx_bit), 32'd1);
    chk("R10", 32'(tx_done), 32'd0);
    bit_en = 1'b1;
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      chk("R10", 32'(tx_bit), 32'(k == 7));
    end
    @(negedge clk);
    bit_en = 1'b0;
    chk("R10", 32'(tx_done), 32'd1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule